// File: doc/BRIEF.md
# Paged Memory Mapping Unit

This block extends a 16-bit CPU address space to a 16 MB physical space. The logical space is cut into sixteen 4 KB pages. The logical page number (address bits 15..12) picks one of sixteen programmable entries, and that entry supplies a 12-bit physical page number. Pages may be placed in any order, and several logical pages may share one physical page. When translation is switched off, the block passes the logical page straight through, so the machine sees its plain 64 KB space.

Each entry is 12 bits wide, but the CPU data bus carries only 8. On a write, the upper nibble comes in on a 4-bit side-band port, which external logic fills before the access. Every register access captures the nibble present on the side-band lines in a small readback latch. A separate enable drives that latch back onto the side-band lines, so software can recover the upper bits. During a CPU register read, the mapper itself drives the entry's upper nibble on those lines and the latch stays off them.

Top module: `page_mapper`

## Requirements
- R1: After reset, every entry holds its own index, so with translation on, logical page n maps to physical page n.
- R2: With map_en low, phys_page equals {8'h00, log_page}, whatever the entries contain.
- R3: With map_en high, phys_page equals the entry selected by log_page, combinationally.
- R4: A clock edge with reg_cs and reg_we both high stores {side_in, cpu_wdata} into the entry selected by reg_sel. side_in forms bits 11..8 and cpu_wdata forms bits 7..0.
- R5: While reg_cs is high and reg_we is low, cpu_rdata shows bits 7..0 of the entry selected by reg_sel. At all other times it reads 8'h00.
- R6: During a register read (reg_cs high, reg_we low), side_oe is high and side_out carries bits 11..8 of the selected entry, not the latch.
- R7: At each clock edge with reg_cs high, the readback latch loads the nibble on the side-band lines: side_in on a write, the entry's upper nibble on a read. Without reg_cs it holds its value.
- R8: With reg_cs low and side_rd_en high, side_oe is high and side_out shows the latch. During a register write, or with neither condition, side_oe is low and side_out is 4'h0.
- R9: Two logical pages programmed with the same value both translate to that same physical page.
- R10: A clock edge with reg_we high but reg_cs low changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_en | input | 1 | Translation enable; low is pass-through |
| log_page | input | 4 | Logical page number (CPU address bits 15..12) |
| phys_page | output | 12 | Physical page number |
| reg_cs | input | 1 | Register access select |
| reg_we | input | 1 | 1 = register write, 0 = register read |
| reg_sel | input | 4 | Entry index for register access (CPU address bits 3..0) |
| cpu_wdata | input | 8 | Low byte for register writes |
| cpu_rdata | output | 8 | Low byte of the entry being read |
| side_in | input | 4 | Upper nibble supplied for writes |
| side_rd_en | input | 1 | Request to drive the latched nibble back |
| side_out | output | 4 | Nibble driven onto the side-band lines |
| side_oe | output | 1 | Side-band drive enable |

## Verification
The hardest condition to reach is recovering the upper nibble through the readback latch. The latch changes only on a register access, and the sequence must show that the latch took the right source: side_in on a write, the entry's upper bits on a read. A write with side-band data that differs from the entry is therefore followed by a read of another entry with different upper bits, and then by an idle cycle with side_rd_en high. After each step the driven nibble is compared with a bench model. Aliasing and pass-through are covered by programming two pages to the same value and then clearing map_en while those non-identity entries are still in place.

// File: rtl/pm_pkg.sv
package pm_pkg;
  parameter int IDX_W  = 4;
  parameter int PHYS_W = 12;
  parameter int DATA_W = 8;
  localparam int NUM_PAGES = 1 << IDX_W;
  localparam int EXT_W     = PHYS_W - DATA_W;
  typedef logic [PHYS_W-1:0] ppage_t;
  typedef logic [IDX_W-1:0]  pidx_t;
endpackage

// File: rtl/pm_regfile.sv
module pm_regfile
  import pm_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_en,
  input  pidx_t  wr_idx,
  input  ppage_t wr_data,
  input  pidx_t  rd_idx_a,
  input  pidx_t  rd_idx_b,
  output ppage_t rd_a,
  output ppage_t rd_b
);
  logic [NUM_PAGES-1:0][PHYS_W-1:0] ent_flat;

  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_ent
    ppage_t ent_q, ent_d;
    logic   ent_ce;

    always_comb begin
      ent_ce = wr_en && (wr_idx == IDX_W'(g));
      ent_d  = ent_q;
      if (ent_ce) ent_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q <= PHYS_W'(g);
      else if (ent_ce) ent_q <= ent_d;
    end

    assign ent_flat[g] = ent_q;
  end

  assign rd_a = ent_flat[rd_idx_a];
  assign rd_b = ent_flat[rd_idx_b];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ent_flat[$past(wr_idx)] == $past(wr_data)); // R4
  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ent_flat)); // R10
endmodule

// File: rtl/pm_translate.sv
module pm_translate
  import pm_pkg::*;
(
  input  logic   map_en,
  input  pidx_t  log_page,
  input  ppage_t entry,
  output ppage_t phys_page
);
  always_comb begin
    if (map_en) phys_page = entry;
    else        phys_page = {{(PHYS_W-IDX_W){1'b0}}, log_page};
  end

  always_comb begin
    if (!map_en) AST_BYPASS_HIGH_ZERO: assert (phys_page[PHYS_W-1:IDX_W] == '0); // R2
  end
endmodule

// File: rtl/pm_sideband.sv
module pm_sideband
  import pm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_cs,
  input  logic             reg_we,
  input  logic             side_rd_en,
  input  logic [EXT_W-1:0] side_in,
  input  logic [EXT_W-1:0] entry_hi,
  output logic [EXT_W-1:0] side_out,
  output logic             side_oe
);
  logic [EXT_W-1:0] latch_q, latch_d, lines;
  logic             latch_ce, rd_access, latch_drive;

  always_comb begin
    rd_access   = reg_cs && !reg_we;
    latch_drive = side_rd_en && !reg_cs;
    lines       = rd_access ? entry_hi : side_in;
    latch_ce    = reg_cs;
    latch_d     = latch_ce ? lines : latch_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        latch_q <= '0;
    else if (latch_ce) latch_q <= latch_d;
  end

  always_comb begin
    side_oe  = rd_access || latch_drive;
    side_out = '0;
    if (rd_access)        side_out = entry_hi;
    else if (latch_drive) side_out = latch_q;
  end

  AST_WRITE_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_cs && reg_we) |-> !side_oe); // R8
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_cs |=> $stable(latch_q)); // R7
  AST_READ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_access |-> (side_oe && side_out == entry_hi)); // R6
endmodule

// File: rtl/page_mapper.sv
module page_mapper
  import pm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        map_en,
  input  logic [3:0]  log_page,
  output logic [11:0] phys_page,
  input  logic        reg_cs,
  input  logic        reg_we,
  input  logic [3:0]  reg_sel,
  input  logic [7:0]  cpu_wdata,
  output logic [7:0]  cpu_rdata,
  input  logic [3:0]  side_in,
  input  logic        side_rd_en,
  output logic [3:0]  side_out,
  output logic        side_oe
);
  logic [1:0] rst_pipe;
  logic       rst_n_int;
  logic       wr_en;
  ppage_t     wr_data, ent_a, ent_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  assign wr_en   = reg_cs && reg_we;
  assign wr_data = {side_in, cpu_wdata};

  pm_regfile i_regfile (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .wr_en    (wr_en),
    .wr_idx   (reg_sel),
    .wr_data  (wr_data),
    .rd_idx_a (log_page),
    .rd_idx_b (reg_sel),
    .rd_a     (ent_a),
    .rd_b     (ent_b)
  );

  pm_translate i_translate (
    .map_en    (map_en),
    .log_page  (log_page),
    .entry     (ent_a),
    .phys_page (phys_page)
  );

  pm_sideband i_sideband (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .reg_cs     (reg_cs),
    .reg_we     (reg_we),
    .side_rd_en (side_rd_en),
    .side_in    (side_in),
    .entry_hi   (ent_b[PHYS_W-1:DATA_W]),
    .side_out   (side_out),
    .side_oe    (side_oe)
  );

  assign cpu_rdata = (reg_cs && !reg_we) ? ent_b[DATA_W-1:0] : '0;

  AST_MAP_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n_int)
    (map_en && $past(wr_en) && log_page == $past(reg_sel)) |-> phys_page == $past(wr_data)); // R3
  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n_int)
    !(reg_cs && !reg_we) |-> cpu_rdata == 8'h00); // R5
endmodule

// File: tb/test_page_mapper.sv
module test_page_mapper;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        map_en, reg_cs, reg_we, side_rd_en;
  logic [3:0]  log_page, reg_sel, side_in, side_out;
  logic [7:0]  cpu_wdata, cpu_rdata;
  logic [11:0] phys_page;
  logic        side_oe;

  typedef struct {
    int          kind;
    logic [11:0] exp;
    string       req;
  } item_t;

  item_t       sb[$];
  int          n_run = 0, n_fail = 0;
  logic [11:0] model [16];
  logic [3:0]  model_latch;
  bit          done = 0;

  always #4 clk = ~clk;

  page_mapper i_page_mapper (
    .clk(clk), .rst_n(rst_n), .map_en(map_en), .log_page(log_page),
    .phys_page(phys_page), .reg_cs(reg_cs), .reg_we(reg_we), .reg_sel(reg_sel),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .side_in(side_in),
    .side_rd_en(side_rd_en), .side_out(side_out), .side_oe(side_oe)
  );

  task automatic push(input int kind, input logic [11:0] exp, input string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    sb.push_back(it);
  endtask

  // monitor: compares queued expectations mid-cycle, before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #3;
      while (sb.size() > 0) begin
        item_t it;
        logic [11:0] act;
        it = sb.pop_front();
        case (it.kind)
          0: act = phys_page;
          1: act = {4'h0, cpu_rdata};
          2: act = {8'h00, side_out};
          default: act = {11'h000, side_oe};
        endcase
        n_run++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic idle();
    reg_cs = 0; reg_we = 0; side_rd_en = 0;
  endtask

  task automatic wr(input logic [3:0] idx, input logic [3:0] hi, input logic [7:0] lo);
    @(negedge clk);
    reg_cs = 1; reg_we = 1; reg_sel = idx; side_in = hi; cpu_wdata = lo;
    push(3, 12'h000, "R8");
    model[idx] = {hi, lo};
    model_latch = hi;
    @(negedge clk);
    idle();
  endtask

  task automatic rd(input logic [3:0] idx);
    @(negedge clk);
    reg_cs = 1; reg_we = 0; reg_sel = idx;
    push(1, {4'h0, model[idx][7:0]}, "R5");
    push(2, {8'h00, model[idx][11:8]}, "R6");
    push(3, 12'h001, "R6");
    model_latch = model[idx][11:8];
    @(negedge clk);
    idle();
  endtask

  task automatic look(input logic me, input logic [3:0] pg, input string req);
    @(negedge clk);
    map_en = me; log_page = pg;
    push(0, me ? model[pg] : {8'h00, pg}, req);
  endtask

  initial begin
    rst_n = 0; map_en = 0; log_page = 0; reg_sel = 0; side_in = 0; cpu_wdata = 0;
    idle();
    for (int i = 0; i < 16; i++) model[i] = 12'(i);
    model_latch = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // reset state
    push(1, 12'h000, "R5");
    push(3, 12'h000, "R8");
    for (int i = 0; i < 16; i++) look(1'b1, 4'(i), "R1");
    // programming with translation off
    map_en = 0;
    wr(4'h5, 4'hA, 8'h3C);
    wr(4'h2, 4'h1, 8'h23);
    wr(4'h7, 4'h1, 8'h23);
    wr(4'hF, 4'hF, 8'hFF);
    look(1'b1, 4'h5, "R3");
    look(1'b1, 4'h2, "R9");
    look(1'b1, 4'h7, "R9");
    look(1'b1, 4'hF, "R3");
    look(1'b0, 4'h5, "R2");
    look(1'b0, 4'hF, "R2");
    // register read back and side-band drive
    rd(4'h5);
    @(negedge clk);
    side_rd_en = 1;
    push(2, {8'h00, model_latch}, "R7");
    push(3, 12'h001, "R8");
    // write captures side_in, not the entry
    wr(4'h9, 4'h6, 8'h81);
    @(negedge clk);
    side_rd_en = 1;
    push(2, {8'h00, model_latch}, "R7");
    @(negedge clk);
    side_rd_en = 0;
    push(3, 12'h000, "R8");
    push(2, 12'h000, "R8");
    // read of a different entry then latch recall
    rd(4'h2);
    @(negedge clk);
    side_rd_en = 1;
    push(2, {8'h00, model_latch}, "R7");
    // write strobe without select is ignored
    @(negedge clk);
    side_rd_en = 0;
    reg_cs = 0; reg_we = 1; reg_sel = 4'h5; side_in = 4'h3; cpu_wdata = 8'h99;
    @(negedge clk);
    idle();
    rd(4'h5);
    look(1'b1, 4'h5, "R10");
    rd(4'h9);
    look(1'b1, 4'h9, "R4");
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule